// File: doc/BRIEF.md
# Merged Physical Register State Tracker

This block keeps the bookkeeping for a single pool of physical registers that serves both as rename buffers and as the architectural register file. A physical register starts out available. An instruction that writes a logical register claims one at dispatch. The register then carries the result once the instruction finishes. When the instruction completes, the register is declared architectural. No data moves at that point: only the register's state changes. The register that held the same logical register before that rename stays architectural until the newer rename completes. At that point it goes back to the free pool.

The tracker holds a two-bit state for every physical register and a map from each logical register to its current physical register. For every allocation it also stores the destination logical register and the physical register the map held before. Completion and cancellation therefore need only the physical index. Rename logic reads a physical tag and a ready flag for a source operand through a lookup port. Completions arrive in program order. Cancellations arrive one per cycle, youngest first. Because a cancel restores the map only when the map still points at the cancelled register, a youngest-first walk of any length leaves the map exactly as it was before the cancelled dispatches.

Top module: `phys_reg_tracker`

## Requirements
- R1: After reset, logical register k maps to physical register k and reads ready for every k below NUM_ARCH; registers NUM_ARCH to NUM_PHYS-1 are available.
- R2: A dispatch takes the lowest-numbered available physical register, shown on disp_phys_o in the same cycle as disp_ready_o.
- R3: After an accepted dispatch, a lookup of the destination logical register returns the new physical register from the next cycle, and that register reads not ready.
- R4: A finish on an allocated-not-valid register makes it read ready from the next cycle; a finish on a register in any other state has no effect.
- R5: A completion of a renamed-valid register makes it architectural and returns the register recorded as its predecessor to the pool; a completion of a register in any other state has no effect.
- R6: A cancel of an allocated (valid or not) register returns it to the pool and, if the map still points at it, restores the map entry to its recorded predecessor; a cancel of an available or architectural register has no effect on state or map.
- R7: disp_ready_o is low when no register is available, and a dispatch offered while disp_ready_o is low changes nothing.
- R8: disp_ready_o is low in any cycle with cncl_valid_i high, whether or not the cancel is effective.
- R9: Right after reset exactly NUM_PHYS-NUM_ARCH dispatches are accepted before the block stalls.
- R10: A register freed by completion or cancel becomes allocatable in the cycle after the event, not the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request with a destination register |
| disp_arch_i | input | AW | Destination logical register |
| disp_ready_o | output | 1 | Dispatch can be accepted this cycle |
| disp_phys_o | output | PW | Physical register given to the dispatch |
| fin_valid_i | input | 1 | Result written for a physical register |
| fin_phys_i | input | PW | Physical register that finished |
| cmt_valid_i | input | 1 | In-order completion |
| cmt_phys_i | input | PW | Physical register of the completing instruction |
| cncl_valid_i | input | 1 | Cancel of the youngest outstanding instruction |
| cncl_phys_i | input | PW | Physical register of the cancelled instruction |
| src_arch_i | input | AW | Logical register to look up |
| src_phys_o | output | PW | Current physical register of src_arch_i |
| src_ready_o | output | 1 | Looked-up register holds valid data |

## Verification
The bench drains the pool to empty and then completes an instruction while a dispatch is waiting. A design that recycled the freed register in the same cycle, or that freed the completing register instead of its predecessor, would hand out the wrong index or accept a dispatch too early. It cancels a chain of renames of one logical register youngest first. A design that skipped the map restore, or that restored it unconditionally, would leave a lookup pointing at a dead or wrong register. It offers finishes, completions and cancels to registers in the wrong state, where a design without state guards would corrupt the ready flag, leak a register or duplicate an architectural copy. A long random mix keeps every output in step with a behavioural model.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [1:0] {
    PR_FREE = 2'd0,  // available
    PR_PEND = 2'd1,  // allocated, result not yet written
    PR_DONE = 2'd2,  // allocated, result valid
    PR_ARCH = 2'd3   // architectural copy of a logical register
  } pr_state_e;
endpackage

// File: rtl/prs_alloc.sv
module prs_alloc #(
  parameter int unsigned NUM_PHYS = 16,
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic [NUM_PHYS-1:0] free_i,
  output logic                any_o,
  output logic [PW-1:0]       idx_o
);
  assign any_o = |free_i;

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int k = NUM_PHYS - 1; k >= 0; k--) begin
      if (free_i[k]) idx_o = PW'(k);
    end
  end
endmodule

// File: rtl/prs_map_table.sv
module prs_map_table #(
  parameter int unsigned NUM_ARCH = 8,
  parameter int unsigned NUM_PHYS = 16,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_arch_i,
  input  logic [PW-1:0] wr_phys_i,
  input  logic          rb_en_i,
  input  logic [AW-1:0] rb_arch_i,
  input  logic [PW-1:0] rb_from_i,
  input  logic [PW-1:0] rb_to_i,
  input  logic [AW-1:0] rd_a_arch_i,
  output logic [PW-1:0] rd_a_phys_o,
  input  logic [AW-1:0] rd_b_arch_i,
  output logic [PW-1:0] rd_b_phys_o
);
  logic [PW-1:0] map_arr [NUM_ARCH];

  for (genvar a = 0; a < NUM_ARCH; a++) begin : g_ent
    logic [PW-1:0] map_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        map_q <= PW'(a);
      end else if (wr_en_i && wr_arch_i == AW'(a)) begin
        map_q <= wr_phys_i;
      end else if (rb_en_i && rb_arch_i == AW'(a) && map_q == rb_from_i) begin
        // roll back only if no younger rename survives
        map_q <= rb_to_i;
      end
    end
    assign map_arr[a] = map_q;
  end

  assign rd_a_phys_o = map_arr[rd_a_arch_i];
  assign rd_b_phys_o = map_arr[rd_b_arch_i];
endmodule

// File: rtl/prs_state_table.sv
module prs_state_table
  import prs_pkg::*;
#(
  parameter int unsigned NUM_ARCH = 8,
  parameter int unsigned NUM_PHYS = 16,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alloc_we_i,
  input  logic [PW-1:0]              alloc_idx_i,
  input  logic [AW-1:0]              alloc_arch_i,
  input  logic [PW-1:0]              alloc_prev_i,
  input  logic                       fin_valid_i,
  input  logic [PW-1:0]              fin_idx_i,
  input  logic                       cmt_valid_i,
  input  logic [PW-1:0]              cmt_idx_i,
  input  logic                       cncl_valid_i,
  input  logic [PW-1:0]              cncl_idx_i,
  output pr_state_e [NUM_PHYS-1:0]   state_o,
  output logic [NUM_PHYS-1:0]        free_o,
  output logic                       cncl_ok_o,
  output logic [AW-1:0]              cncl_arch_o,
  output logic [PW-1:0]              cncl_prev_o
);
  logic [AW-1:0] arch_arr [NUM_PHYS];
  logic [PW-1:0] prev_arr [NUM_PHYS];
  logic          fin_ok, cmt_ok, cncl_ok;
  logic [PW-1:0] rec_idx;

  assign cncl_ok = cncl_valid_i &&
                   (state_o[cncl_idx_i] == PR_PEND || state_o[cncl_idx_i] == PR_DONE);
  assign cmt_ok  = cmt_valid_i && state_o[cmt_idx_i] == PR_DONE &&
                   !(cncl_ok && cncl_idx_i == cmt_idx_i);
  assign fin_ok  = fin_valid_i && state_o[fin_idx_i] == PR_PEND &&
                   !(cncl_ok && cncl_idx_i == fin_idx_i);
  assign rec_idx = prev_arr[cmt_idx_i];

  for (genvar i = 0; i < NUM_PHYS; i++) begin : g_reg
    localparam pr_state_e RstSt = (i < NUM_ARCH) ? PR_ARCH : PR_FREE;
    pr_state_e     st_q;
    logic [AW-1:0] arch_q;
    logic [PW-1:0] prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q   <= RstSt;
        arch_q <= '0;
        prev_q <= '0;
      end else if (cncl_ok && cncl_idx_i == PW'(i)) begin
        st_q <= PR_FREE;
      end else if (cmt_ok && cmt_idx_i == PW'(i)) begin
        st_q <= PR_ARCH;            // becomes architectural in place
      end else if (cmt_ok && rec_idx == PW'(i)) begin
        st_q <= PR_FREE;            // superseded architectural copy
      end else if (fin_ok && fin_idx_i == PW'(i)) begin
        st_q <= PR_DONE;
      end else if (alloc_we_i && alloc_idx_i == PW'(i)) begin
        st_q   <= PR_PEND;
        arch_q <= alloc_arch_i;
        prev_q <= alloc_prev_i;
      end
    end

    assign state_o[i]  = st_q;
    assign free_o[i]   = (st_q == PR_FREE);
    assign arch_arr[i] = arch_q;
    assign prev_arr[i] = prev_q;
  end

  assign cncl_ok_o   = cncl_ok;
  assign cncl_arch_o = arch_arr[cncl_idx_i];
  assign cncl_prev_o = prev_arr[cncl_idx_i];
endmodule

// File: rtl/phys_reg_tracker.sv
module phys_reg_tracker
  import prs_pkg::*;
#(
  parameter int unsigned NUM_ARCH = 8,
  parameter int unsigned NUM_PHYS = 16,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          disp_valid_i,
  input  logic [AW-1:0] disp_arch_i,
  output logic          disp_ready_o,
  output logic [PW-1:0] disp_phys_o,
  input  logic          fin_valid_i,
  input  logic [PW-1:0] fin_phys_i,
  input  logic          cmt_valid_i,
  input  logic [PW-1:0] cmt_phys_i,
  input  logic          cncl_valid_i,
  input  logic [PW-1:0] cncl_phys_i,
  input  logic [AW-1:0] src_arch_i,
  output logic [PW-1:0] src_phys_o,
  output logic          src_ready_o
);
  pr_state_e [NUM_PHYS-1:0] state_q;
  logic [NUM_PHYS-1:0]      free_vec;
  logic                     any_free, disp_fire, cncl_ok;
  logic [PW-1:0]            alloc_idx, prev_phys, cncl_prev;
  logic [AW-1:0]            cncl_arch;

  prs_alloc #(.NUM_PHYS(NUM_PHYS)) u_alloc (
    .free_i (free_vec),
    .any_o  (any_free),
    .idx_o  (alloc_idx)
  );

  // a cancel walk owns the map for the cycle
  assign disp_ready_o = any_free & ~cncl_valid_i;
  assign disp_fire    = disp_valid_i & disp_ready_o;
  assign disp_phys_o  = alloc_idx;

  prs_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (disp_fire),
    .wr_arch_i   (disp_arch_i),
    .wr_phys_i   (alloc_idx),
    .rb_en_i     (cncl_ok),
    .rb_arch_i   (cncl_arch),
    .rb_from_i   (cncl_phys_i),
    .rb_to_i     (cncl_prev),
    .rd_a_arch_i (src_arch_i),
    .rd_a_phys_o (src_phys_o),
    .rd_b_arch_i (disp_arch_i),
    .rd_b_phys_o (prev_phys)
  );

  prs_state_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_we_i   (disp_fire),
    .alloc_idx_i  (alloc_idx),
    .alloc_arch_i (disp_arch_i),
    .alloc_prev_i (prev_phys),
    .fin_valid_i  (fin_valid_i),
    .fin_idx_i    (fin_phys_i),
    .cmt_valid_i  (cmt_valid_i),
    .cmt_idx_i    (cmt_phys_i),
    .cncl_valid_i (cncl_valid_i),
    .cncl_idx_i   (cncl_phys_i),
    .state_o      (state_q),
    .free_o       (free_vec),
    .cncl_ok_o    (cncl_ok),
    .cncl_arch_o  (cncl_arch),
    .cncl_prev_o  (cncl_prev)
  );

  assign src_ready_o = (state_q[src_phys_o] == PR_DONE) || (state_q[src_phys_o] == PR_ARCH);
endmodule

// File: rtl/phys_reg_tracker_chk.sv
module phys_reg_tracker_chk
  import prs_pkg::*;
#(
  parameter int unsigned NUM_ARCH = 8,
  parameter int unsigned NUM_PHYS = 16,
  parameter int unsigned PW = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  disp_valid_i,
  input logic                  disp_ready_o,
  input logic [PW-1:0]         disp_phys_o,
  input logic                  fin_valid_i,
  input logic [PW-1:0]         fin_phys_i,
  input logic                  cmt_valid_i,
  input logic [PW-1:0]         cmt_phys_i,
  input logic                  cncl_valid_i,
  input logic [PW-1:0]         cncl_phys_i,
  input logic [2*NUM_PHYS-1:0] st_i
);
  function automatic pr_state_e st_at(input logic [2*NUM_PHYS-1:0] v, input logic [PW-1:0] idx);
    return pr_state_e'(v[2*idx +: 2]);
  endfunction

  logic [NUM_PHYS-1:0] arch_mask;
  always_comb begin
    for (int k = 0; k < NUM_PHYS; k++) arch_mask[k] = (st_at(st_i, PW'(k)) == PR_ARCH);
  end

  logic cncl_live;
  assign cncl_live = cncl_valid_i &&
                     (st_at(st_i, cncl_phys_i) == PR_PEND || st_at(st_i, cncl_phys_i) == PR_DONE);

  a_r2_take_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && disp_ready_o) |-> st_at(st_i, disp_phys_o) == PR_FREE);

  a_r3_alloc_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && disp_ready_o) |=> st_at(st_i, $past(disp_phys_o)) == PR_PEND);

  a_r4_finish_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_valid_i && st_at(st_i, fin_phys_i) == PR_PEND && !(cncl_live && cncl_phys_i == fin_phys_i))
    |=> st_at(st_i, $past(fin_phys_i)) == PR_DONE);

  a_r5_commit_arch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_valid_i && st_at(st_i, cmt_phys_i) == PR_DONE && !(cncl_live && cncl_phys_i == cmt_phys_i))
    |=> st_at(st_i, $past(cmt_phys_i)) == PR_ARCH);

  a_r5_arch_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(arch_mask) == NUM_ARCH);

  a_r6_cancel_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cncl_live |=> st_at(st_i, $past(cncl_phys_i)) == PR_FREE);

  a_r8_cancel_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cncl_valid_i |-> !(disp_valid_i && disp_ready_o));
endmodule

bind phys_reg_tracker phys_reg_tracker_chk #(
  .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .PW(PW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .disp_valid_i (disp_valid_i),
  .disp_ready_o (disp_ready_o),
  .disp_phys_o  (disp_phys_o),
  .fin_valid_i  (fin_valid_i),
  .fin_phys_i   (fin_phys_i),
  .cmt_valid_i  (cmt_valid_i),
  .cmt_phys_i   (cmt_phys_i),
  .cncl_valid_i (cncl_valid_i),
  .cncl_phys_i  (cncl_phys_i),
  .st_i         (state_q)
);

// File: tb/phys_reg_tracker_test.sv
`timescale 1ns/1ps
module phys_reg_tracker_test;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int AW = $clog2(NA);
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic disp_valid_i = 1'b0, fin_valid_i = 1'b0, cmt_valid_i = 1'b0, cncl_valid_i = 1'b0;
  logic [AW-1:0] disp_arch_i = '0, src_arch_i = '0;
  logic [PW-1:0] fin_phys_i = '0, cmt_phys_i = '0, cncl_phys_i = '0;
  logic disp_ready_o, src_ready_o;
  logic [PW-1:0] disp_phys_o, src_phys_o;

  always #2.5 clk = ~clk;

  phys_reg_tracker #(.NUM_ARCH(NA), .NUM_PHYS(NP)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .disp_valid_i(disp_valid_i), .disp_arch_i(disp_arch_i),
    .disp_ready_o(disp_ready_o), .disp_phys_o(disp_phys_o),
    .fin_valid_i(fin_valid_i), .fin_phys_i(fin_phys_i),
    .cmt_valid_i(cmt_valid_i), .cmt_phys_i(cmt_phys_i),
    .cncl_valid_i(cncl_valid_i), .cncl_phys_i(cncl_phys_i),
    .src_arch_i(src_arch_i), .src_phys_o(src_phys_o), .src_ready_o(src_ready_o)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model: 0 free, 1 waiting, 2 result valid, 3 architectural
  int m_st [NP];
  int m_map [NA];
  int m_arch [NP];
  int m_prev [NP];
  int rob [$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      m_st[p] = (p < NA) ? 3 : 0;
      m_arch[p] = 0;
      m_prev[p] = 0;
    end
    for (int a = 0; a < NA; a++) m_map[a] = a;
    rob.delete();
  endtask

  function automatic int lowest_free();
    for (int p = 0; p < NP; p++) if (m_st[p] == 0) return p;
    return -1;
  endfunction

  task automatic apply(bit dv, int da, bit fv, int fp, bit mv, int mp, bit cv, int cp, int sa);
    disp_valid_i = dv; disp_arch_i = AW'(da);
    fin_valid_i = fv;  fin_phys_i = PW'(fp);
    cmt_valid_i = mv;  cmt_phys_i = PW'(mp);
    cncl_valid_i = cv; cncl_phys_i = PW'(cp);
    src_arch_i = AW'(sa);
    #1;
  endtask

  // compare every output, then advance the model over the coming edge
  task automatic step();
    int lf, sp, f, m, c;
    bit rdy, fire, cok, mok, fok;
    int n_st [NP];
    int n_map [NA];
    int n_arch [NP];
    int n_prev [NP];
    lf = lowest_free();
    rdy = (lf >= 0) && !cncl_valid_i;
    chk("R7 disp_ready", int'(disp_ready_o), int'(rdy));
    if (lf >= 0) chk("R2 disp_phys", int'(disp_phys_o), lf);
    sp = m_map[src_arch_i];
    chk("R3 src_phys", int'(src_phys_o), sp);
    chk("R4 src_ready", int'(src_ready_o), int'(m_st[sp] >= 2));

    f = fin_phys_i; m = cmt_phys_i; c = cncl_phys_i;
    fire = disp_valid_i && rdy;
    cok = cncl_valid_i && (m_st[c] == 1 || m_st[c] == 2);
    mok = cmt_valid_i && m_st[m] == 2 && !(cok && c == m);
    fok = fin_valid_i && m_st[f] == 1 && !(cok && c == f);
    n_st = m_st; n_map = m_map; n_arch = m_arch; n_prev = m_prev;
    if (fok) n_st[f] = 2;
    if (mok) begin n_st[m] = 3; n_st[m_prev[m]] = 0; void'(rob.pop_front()); end
    if (cok) begin
      n_st[c] = 0;
      if (m_map[m_arch[c]] == c) n_map[m_arch[c]] = m_prev[c];
      void'(rob.pop_back());
    end
    if (fire) begin
      n_st[lf] = 1; n_arch[lf] = disp_arch_i; n_prev[lf] = m_map[disp_arch_i];
      n_map[disp_arch_i] = lf;
      rob.push_back(lf);
    end
    m_st = n_st; m_map = n_map; m_arch = n_arch; m_prev = n_prev;
    @(negedge clk);
  endtask

  task automatic idle(int sa);
    apply(0, 0, 0, 0, 0, 0, 0, 0, sa);
    step();
  endtask

  initial begin
    int acc;
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: identity map, all architectural copies ready
    for (int a = 0; a < NA; a++) begin
      apply(0, 0, 0, 0, 0, 0, 0, 0, a);
      chk("R1 reset map", int'(src_phys_o), a);
      chk("R1 reset ready", int'(src_ready_o), 1);
      step();
    end

    // R9: drain the pool with renames of logical 1
    acc = 0;
    for (int k = 0; k < NP; k++) begin
      apply(1, 1, 0, 0, 0, 0, 0, 0, 1);
      if (disp_ready_o) acc++;
      step();
    end
    chk("R9 accepted before stall", acc, NP - NA);
    idle(1);

    // wrong-state events: completion of a waiting register, finish and cancel of an architectural one
    apply(0, 0, 1, 3, 1, 8, 0, 0, 3);
    step();
    apply(0, 0, 0, 0, 0, 0, 1, 3, 3);
    chk("R8 cancel blocks", int'(disp_ready_o), 0);
    step();
    apply(0, 0, 0, 0, 0, 0, 0, 0, 3);
    chk("R6 ignored cancel keeps map", int'(src_phys_o), 3);
    chk("R6 ignored cancel keeps ready", int'(src_ready_o), 1);
    step();
    idle(1);

    // finish then complete the oldest with the pool empty
    apply(0, 0, 1, 8, 0, 0, 0, 0, 1);
    step();
    apply(1, 2, 0, 0, 1, 8, 0, 0, 1);
    chk("R10 freed not usable same cycle", int'(disp_ready_o), 0);
    step();
    apply(1, 2, 0, 0, 0, 0, 0, 0, 2);
    chk("R10 freed usable next cycle", int'(disp_ready_o), 1);
    chk("R5 predecessor reclaimed", int'(disp_phys_o), 1);
    step();

    // youngest-first cancel walk
    apply(1, 5, 0, 0, 0, 0, 1, 1, 2);
    chk("R8 cancel blocks dispatch", int'(disp_ready_o), 0);
    step();
    apply(0, 0, 0, 0, 0, 0, 1, 15, 2);
    chk("R6 map restored", int'(src_phys_o), 2);
    chk("R6 restored ready", int'(src_ready_o), 1);
    step();
    apply(0, 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R6 map restored chain", int'(src_phys_o), 14);
    chk("R6 restored not ready", int'(src_ready_o), 0);
    step();

    // random legal traffic with stray finishes
    for (int n = 0; n < 3000; n++) begin
      bit dv, fv, mv, cv;
      int fp, mp, cp;
      dv = ($urandom_range(0, 1) == 1);
      fv = 0; fp = 0; mv = 0; mp = 0; cv = 0; cp = 0;
      if ($urandom_range(0, 3) == 0) begin
        fv = 1; fp = $urandom_range(0, NP - 1);
      end else if (rob.size() > 0 && $urandom_range(0, 1) == 1) begin
        fv = 1; fp = rob[$urandom_range(0, rob.size() - 1)];
      end
      if (rob.size() > 0 && $urandom_range(0, 1) == 1) begin
        mv = 1; mp = rob[0];
      end
      if (rob.size() > 0 && $urandom_range(0, 9) == 0) begin
        cv = 1; cp = rob[rob.size() - 1];
      end
      apply(dv, $urandom_range(0, NA - 1), fv, fp, mv, mp, cv, cp, $urandom_range(0, NA - 1));
      step();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule